// File: doc/BRIEF.md
# Double-Buffered Receive Endpoint FIFO

This block holds OUT-direction packets for one bulk endpoint in two equal buffers of 64 bytes. The USB side streams bytes into whichever buffer is free while the CPU drains the other. A latched receive size register shows the CPU how many bytes the buffer it currently owns holds.

The CPU returns a buffer by pulsing a read-finished trigger. That pulse hands the CPU the other buffer, reloads the size register from that buffer's packet length, and frees the drained buffer for the next packet. When both buffers hold unread packets, the USB side sees not-ready, which it turns into a NAK handshake.

Reads past the latched size return zero and raise a sticky error. A flush request empties both buffers, but only when no transfer is under way. A request during a transfer is dropped and reported.

The byte stream uses valid/ready. A byte moves on a clock edge where `in_valid` and `in_ready` are both high. `in_data` and `in_last` must stay stable while `in_valid` waits for `in_ready`. `in_ready` falls only between packets, when both buffers are full, and it stays low until the CPU frees one.

Top module: `usb_rx_dbuf`

## Requirements
- R1: After reset, `in_ready` is 1 and `rx_nak`, `rd_size`, `rd_dval`, `ovr_err` and `clr_rej` are 0.
- R2: A byte is taken on every edge with `in_valid` and `in_ready` high, and `in_last` marks the final byte of a packet. A packet keeps at most 64 bytes: later bytes are discarded and its length stays 64.
- R3: When a packet completes while the CPU owns no packet, `rd_size` shows its length right after the edge that takes the last byte.
- R4: A packet that arrives while the CPU owns one goes into the other buffer and leaves `rd_size` unchanged.
- R5: With both buffers full, `in_ready` is 0 and `rx_nak` is 1.
- R6: A `rd_req` pulse returns the next byte on `rd_data` with `rd_dval` high after the following edge, in arrival order starting at the packet's first byte.
- R7: `rd_done` while the CPU owns a packet frees that buffer (`in_ready` 1, `rx_nak` 0) and passes ownership to the other buffer. `rd_size` becomes that buffer's length, or 0 if it is empty, and reading restarts at byte 0.
- R8: `rd_done` while the CPU owns no packet changes nothing. A packet received afterwards reads back intact.
- R9: A `rd_req` made when `rd_size` bytes have already been read since the last ownership change returns `rd_data` 0 and sets `ovr_err`. `ovr_err` stays set until a flush is accepted.
- R10: A `fifo_clr` pulse with no partial packet and no partial read empties both buffers: `rd_size` 0, `in_ready` 1, `rx_nak` 0, `ovr_err` 0.
- R11: A `fifo_clr` pulse during a partial packet, or after at least one byte of a packet has been read and before `rd_done`, is ignored. `clr_rej` is then 1 for the one cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | USB side byte valid |
| in_data | input | 8 | USB side byte |
| in_last | input | 1 | Final byte of packet |
| in_ready | output | 1 | Block can take a byte |
| rx_nak | output | 1 | Both buffers full, answer NAK |
| rd_req | input | 1 | CPU read one byte |
| rd_done | input | 1 | CPU read-finished trigger |
| rd_data | output | 8 | Byte returned to CPU |
| rd_dval | output | 1 | `rd_data` holds a reply |
| rd_size | output | 7 | Byte count of the buffer the CPU owns |
| fifo_clr | input | 1 | Flush request |
| clr_rej | output | 1 | Flush request was refused |
| ovr_err | output | 1 | Sticky over-read flag |

## Verification
On every cycle, the assertions check the following:
- a packet never completes into an occupied buffer;
- the size register and write pointer stay within 64;
- an idle read-finished pulse leaves ownership alone;
- a swap really frees the drained buffer;
- over-reads yield zero with a sticky flag;
- a flush during a transfer is refused.

Only the bench scenarios can show that data comes back byte-exact and in order for every packet length. They also show the ordering across the two buffers, truncation of oversized packets, and that an accepted flush really loses the held packets.

// File: rtl/usb_rxb_pkg.sv
package usb_rxb_pkg;
  // bits needed to hold a count from 0 up to and including d
  function automatic int unsigned cnt_width(input int unsigned d);
    return $clog2(d + 1);
  endfunction
endpackage

// File: rtl/usb_rxb_bank.sv
module usb_rxb_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/usb_rxb_wr.sv
module usb_rxb_wr #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = usb_rxb_pkg::cnt_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          in_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          pkt_end,
  output logic [CW-1:0] pkt_len,
  output logic          busy
);
  logic [CW-1:0] ptr_q;
  logic          take;
  logic          room;

  assign take    = in_valid & in_ready;
  assign room    = ptr_q < CW'(DEPTH);
  assign wr_en   = take & room;
  assign wr_addr = ptr_q[AW-1:0];
  assign pkt_end = take & in_last;
  assign pkt_len = room ? ptr_q + CW'(1) : ptr_q;
  assign busy    = ptr_q != '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (pkt_end) ptr_q <= '0;
    else if (wr_en)   ptr_q <= ptr_q + CW'(1);
  end

  AST_WPTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= CW'(DEPTH)); // R2
endmodule

// File: rtl/usb_rxb_own.sv
module usb_rxb_own #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = usb_rxb_pkg::cnt_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_end,
  input  logic [CW-1:0] pkt_len,
  input  logic          rd_done,
  input  logic          clr_ok,
  output logic [1:0]    full,
  output logic          vsel,
  output logic          wsel,
  output logic [CW-1:0] rd_size
);
  logic [1:0]         full_q, full_n;
  logic [1:0][CW-1:0] cnt_q, cnt_n;
  logic               vsel_q, vsel_n;
  logic [CW-1:0]      size_q, size_n;
  logic               swap;

  assign swap = rd_done & full_q[vsel_q];
  assign wsel = full_q[vsel_q] ? ~vsel_q : vsel_q;

  always_comb begin
    full_n = full_q;
    cnt_n  = cnt_q;
    vsel_n = vsel_q;
    if (clr_ok) begin
      full_n = '0;
      vsel_n = 1'b0;
    end else begin
      if (swap) begin
        full_n[vsel_q] = 1'b0;
        vsel_n         = ~vsel_q;
      end
      if (pkt_end) begin
        full_n[wsel] = 1'b1;
        cnt_n[wsel]  = pkt_len;
      end
    end
    size_n = full_n[vsel_n] ? cnt_n[vsel_n] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= '0;
      cnt_q  <= '0;
      vsel_q <= 1'b0;
      size_q <= '0;
    end else begin
      full_q <= full_n;
      cnt_q  <= cnt_n;
      vsel_q <= vsel_n;
      size_q <= size_n;
    end
  end

  assign full    = full_q;
  assign vsel    = vsel_q;
  assign rd_size = size_q;

  AST_FILL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> !full_q[wsel]); // R5
  AST_SIZE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    size_q <= CW'(DEPTH)); // R2
  AST_SWAP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    swap && !clr_ok |=> !full_q[$past(vsel_q)] && vsel_q != $past(vsel_q)); // R7
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && !full_q[vsel_q] && !pkt_end && !clr_ok |=> $stable(vsel_q) && $stable(size_q)); // R8
endmodule

// File: rtl/usb_rxb_rd.sv
module usb_rxb_rd #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = usb_rxb_pkg::cnt_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              rd_done,
  input  logic              clr_ok,
  input  logic [CW-1:0]     size,
  input  logic [DATA_W-1:0] mem_data,
  output logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_dval,
  output logic              ovr_err,
  output logic              busy
);
  logic [CW-1:0] ptr_q;
  logic          in_range;

  assign in_range = ptr_q < size;
  assign rd_addr  = ptr_q[AW-1:0];
  assign busy     = ptr_q != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      rd_data <= '0;
      rd_dval <= 1'b0;
      ovr_err <= 1'b0;
    end else begin
      rd_dval <= rd_req;
      if (rd_req) rd_data <= in_range ? mem_data : '0;
      if (rd_done || clr_ok)        ptr_q <= '0;
      else if (rd_req && in_range)  ptr_q <= ptr_q + CW'(1);
      if (clr_ok)                   ovr_err <= 1'b0;
      else if (rd_req && !in_range) ovr_err <= 1'b1;
    end
  end

  AST_OVR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !in_range |=> rd_dval && rd_data == '0); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err && !clr_ok |=> ovr_err); // R9
  AST_RPTR_IN_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= size); // R6
endmodule

// File: rtl/usb_rx_dbuf.sv
module usb_rx_dbuf #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = usb_rxb_pkg::cnt_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              rx_nak,
  input  logic              rd_req,
  input  logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_dval,
  output logic [CW-1:0]     rd_size,
  input  logic              fifo_clr,
  output logic              clr_rej,
  output logic              ovr_err
);
  logic              wr_en, pkt_end, wr_busy, rd_busy, clr_ok;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [CW-1:0]     pkt_len;
  logic [1:0]        full;
  logic              vsel, wsel;
  logic [DATA_W-1:0] bank_q [2];

  assign rx_nak   = &full;
  assign in_ready = ~rx_nak;
  assign clr_ok   = fifo_clr & ~wr_busy & ~rd_busy;

  usb_rxb_wr #(.DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
    .pkt_end(pkt_end), .pkt_len(pkt_len), .busy(wr_busy)
  );

  usb_rxb_own #(.DEPTH(DEPTH)) u_own (
    .clk(clk), .rst_n(rst_n), .pkt_end(pkt_end), .pkt_len(pkt_len),
    .rd_done(rd_done), .clr_ok(clr_ok), .full(full), .vsel(vsel),
    .wsel(wsel), .rd_size(rd_size)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    usb_rxb_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
      .clk(clk), .we(wr_en && (wsel == 1'(b))), .waddr(wr_addr),
      .wdata(in_data), .raddr(rd_addr), .rdata(bank_q[b])
    );
  end

  usb_rxb_rd #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_done(rd_done),
    .clr_ok(clr_ok), .size(rd_size), .mem_data(bank_q[vsel]),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_dval(rd_dval),
    .ovr_err(ovr_err), .busy(rd_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) clr_rej <= 1'b0;
    else        clr_rej <= fifo_clr & ~clr_ok;
  end

  AST_CLR_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr && (wr_busy || rd_busy) |=> clr_rej); // R11
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok |=> !rx_nak && rd_size == '0 && !ovr_err); // R10
endmodule

// File: tb/usb_rx_dbuf_test.sv
module usb_rx_dbuf_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic       rd_req = 1'b0, rd_done = 1'b0, fifo_clr = 1'b0;
  logic       in_ready, rx_nak, rd_dval, clr_rej, ovr_err;
  logic [7:0] rd_data;
  logic [6:0] rd_size;
  int total = 0, bad = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  usb_rx_dbuf uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .rx_nak(rx_nak),
    .rd_req(rd_req), .rd_done(rd_done), .rd_data(rd_data),
    .rd_dval(rd_dval), .rd_size(rd_size), .fifo_clr(fifo_clr),
    .clr_rej(clr_rej), .ovr_err(ovr_err)
  );

  function automatic logic [7:0] pat(input int base, input int i);
    return 8'((base + i * 3) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int n, input int base, input int first, input bit fin);
    for (int i = first; i < first + n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = pat(base, i);
      in_last  = fin && (i == first + n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic rd_one(input int exp, input string req);
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_dval && rd_data == 8'(exp), req, int'(rd_data), exp);
  endtask

  task automatic done_pulse();
    @(negedge clk);
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
  endtask

  task automatic clr_pulse();
    @(negedge clk);
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(rx_nak == 1'b0 && rd_dval == 1'b0, "R1 nak/dval", int'(rx_nak), 0);
    chk(rd_size == 0, "R1 rd_size", int'(rd_size), 0);
    chk(ovr_err == 1'b0 && clr_rej == 1'b0, "R1 flags", int'(ovr_err), 0);

    // sweep every packet length
    for (int len = 1; len <= 64; len++) begin
      send(len, len * 5, 0, 1'b1);
      chk(rd_size == 7'(len), "R3 size after packet", int'(rd_size), len);
      chk(in_ready && !rx_nak, "R4 one buffer free", int'(rx_nak), 0);
      for (int i = 0; i < len; i++) rd_one(int'(pat(len * 5, i)), "R6 read order");
      rd_one(0, "R9 overread data");
      chk(ovr_err == 1'b1, "R9 ovr_err set", int'(ovr_err), 1);
      done_pulse();
      chk(rd_size == 0, "R7 size after swap to empty", int'(rd_size), 0);
      chk(ovr_err == 1'b1, "R9 ovr_err sticky", int'(ovr_err), 1);
      clr_pulse();
      chk(clr_rej == 1'b0, "R10 clear accepted", int'(clr_rej), 0);
      chk(ovr_err == 1'b0, "R10 ovr_err cleared", int'(ovr_err), 0);
    end

    // two buffers in turn
    send(10, 40, 0, 1'b1);
    send(20, 90, 0, 1'b1);
    chk(rd_size == 10, "R4 size holds first", int'(rd_size), 10);
    chk(rx_nak && !in_ready, "R5 both full nak", int'(rx_nak), 1);
    for (int i = 0; i < 10; i++) rd_one(int'(pat(40, i)), "R6 first packet");
    done_pulse();
    chk(rd_size == 20, "R7 size reload", int'(rd_size), 20);
    chk(!rx_nak && in_ready, "R7 buffer freed", int'(rx_nak), 0);
    send(5, 150, 0, 1'b1);
    chk(rx_nak == 1'b1, "R5 full again", int'(rx_nak), 1);
    chk(rd_size == 20, "R4 size unchanged", int'(rd_size), 20);
    for (int i = 0; i < 20; i++) rd_one(int'(pat(90, i)), "R7 second packet restart");
    done_pulse();
    chk(rd_size == 5, "R7 size third", int'(rd_size), 5);
    for (int i = 0; i < 5; i++) rd_one(int'(pat(150, i)), "R6 third packet");
    done_pulse();
    chk(rd_size == 0, "R7 empty", int'(rd_size), 0);
    done_pulse();
    chk(rd_size == 0 && in_ready && !rx_nak, "R8 idle done", int'(rd_size), 0);
    send(3, 200, 0, 1'b1);
    chk(rd_size == 3, "R8 packet after idle done", int'(rd_size), 3);
    for (int i = 0; i < 3; i++) rd_one(int'(pat(200, i)), "R8 data intact");
    done_pulse();

    // oversize packet is truncated
    send(70, 7, 0, 1'b1);
    chk(rd_size == 64, "R2 truncated length", int'(rd_size), 64);
    for (int i = 0; i < 64; i++) rd_one(int'(pat(7, i)), "R2 kept bytes");
    rd_one(0, "R9 overread after 64");
    done_pulse();
    clr_pulse();

    // flush refused while busy
    send(3, 60, 0, 1'b0);
    clr_pulse();
    chk(clr_rej == 1'b1, "R11 clear mid packet", int'(clr_rej), 1);
    @(negedge clk);
    chk(clr_rej == 1'b0, "R11 one cycle", int'(clr_rej), 0);
    send(1, 60, 3, 1'b1);
    chk(rd_size == 4, "R11 packet survives", int'(rd_size), 4);
    rd_one(int'(pat(60, 0)), "R11 read byte0");
    clr_pulse();
    chk(clr_rej == 1'b1, "R11 clear mid read", int'(clr_rej), 1);
    for (int i = 1; i < 4; i++) rd_one(int'(pat(60, i)), "R11 rest intact");
    done_pulse();

    // flush with both buffers held
    send(8, 11, 0, 1'b1);
    send(9, 22, 0, 1'b1);
    chk(rx_nak == 1'b1, "R5 full before flush", int'(rx_nak), 1);
    clr_pulse();
    chk(clr_rej == 1'b0 && rd_size == 0, "R10 flush size", int'(rd_size), 0);
    chk(in_ready && !rx_nak, "R10 flush frees", int'(rx_nak), 0);
    rd_one(0, "R10 nothing left");
    send(2, 33, 0, 1'b1);
    chk(rd_size == 2, "R10 refill after flush", int'(rd_size), 2);
    rd_one(int'(pat(33, 0)), "R10 refill data");

    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule